// File: doc/BRIEF.md
# Slot-Based Module Bus Decoder

This block sits between a host bus and a row of slots, each holding a swappable slave module. It splits every host address into three fields. The bits above a 4-bit slot field are compared against one subsystem base address. The 4-bit field picks a slot. The low offset bits go unchanged to the chosen module as its register offset. To the host, the whole row of slots appears as one ordinary slave that returns an acknowledge for every access inside its window.

A slot does not answer to a fixed code. Each slot has a select-code register that can be written at runtime, so several copies of one module can sit at different addresses. The slot-field value 4'hF is reserved: it never selects a module. It opens a control page where the offset names a slot index, and the data writes or reads that slot's code. Every code register starts at 4'hF after reset, so a slot stays silent until it has been given a code.

The block also produces a reset for each slot. That reset is held while the slot is being loaded, and it can be merged with a global reset. A parameter adds one register stage on the request path. This costs one cycle of latency in exchange for a shorter path from the host.

Top module: `slot_bus_decoder`

## Requirements
- R1: `slotOffs` always carries the low `OFFS_W` bits of the request address, and `slotWdata` carries the write data, both unchanged.
- R2: A request whose bits above the slot field differ from `BASE` gets no acknowledge and drives no slot select.
- R3: A request inside the window whose slot field (bits `OFFS_W+3:OFFS_W`) equals a slot's programmed code, and is not 4'hF, asserts that slot's `slotSel` bit. The read returns that slot's `slotRdata` word.
- R4: After reset every slot code is 4'hF, so no slot select asserts until a code has been written.
- R5: When the slot field is 4'hF, the access goes to the control page. A write stores `hostWdata[3:0]` as the code of the slot whose index equals the offset. A read returns that code in the low 4 bits, with zeros above. An index at or above `SLOTS` reads zero and writes nothing.
- R6: If two slots hold the same code (other than 4'hF), both selects assert. The read data is the bitwise OR of their words, and `codeClash` is high while the duplicate exists.
- R7: A read inside the window that selects no slot returns all zeros with the same acknowledge latency as a normal access. Writes also return zero data.
- R8: `slotRst[i]` is high whenever `slotLoading[i]` is high. When `GLB_RST_EN` is set, it is also high whenever `globalRst` is high.
- R9: `hostAck` follows an accepted request by 1 cycle when `PIPE`=0, and by 2 cycles when `PIPE`=1.
- R10: `slotWe` pulses only on a data write that selects at least one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| hostSel | input | 1 | host request strobe, one cycle per access |
| hostWe | input | 1 | request is a write |
| hostAddr | input | ADDR_W | request address |
| hostWdata | input | DATA_W | write data |
| hostRdata | output | DATA_W | read data, valid with hostAck |
| hostAck | output | 1 | access completed |
| slotSel | output | SLOTS | per-slot chip select |
| slotWe | output | 1 | write strobe to the selected slots |
| slotOffs | output | OFFS_W | register offset to the modules |
| slotWdata | output | DATA_W | write data to the modules |
| slotRdata | input | SLOTS*DATA_W | read words of the slots, slot 0 in the low word |
| slotLoading | input | SLOTS | slot is being reloaded |
| globalRst | input | 1 | global module reset request |
| slotRst | output | SLOTS | reset seen by each module |
| codeClash | output | 1 | two slots share a select code |

## Verification
The hardest case to reach from the ports is a duplicate-code conflict. The bench first programs two slots with distinct codes, then rewrites a third slot with one of those codes through the control page. A single read then has to return the OR of two slot words, and the conflict flag must go high. Writing 4'hF back to that slot clears the flag. A second instance with the pipeline stage enabled receives the same traffic, and the bench checks that its acknowledge is missing after one cycle and present after two.

// File: rtl/slotbus_pkg.sv
package slotbus_pkg;
  localparam logic [3:0] CODE_NONE = 4'hF;

  typedef struct packed {
    logic       hit;
    logic       ctrl;
    logic       we;
    logic [3:0] field;
  } strobe_t;
endpackage

// File: rtl/slotbus_ctrl.sv
module slotbus_ctrl
  import slotbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFFS_W = 4,
  parameter int unsigned BASE   = 'hA5,
  parameter bit          PIPE   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output strobe_t           strb,
  output logic [OFFS_W-1:0] offs,
  output logic [DATA_W-1:0] wdata,
  output logic              hostAck
);
  localparam int unsigned BASE_W = ADDR_W - OFFS_W - 4;

  logic              stSel;
  logic              stWe;
  logic [ADDR_W-1:0] stAddr;
  logic [DATA_W-1:0] stWdata;

  generate
    if (PIPE) begin : g_pipe
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stSel   <= 1'b0;
          stWe    <= 1'b0;
          stAddr  <= '0;
          stWdata <= '0;
        end else begin
          stSel   <= hostSel;
          stWe    <= hostWe;
          stAddr  <= hostAddr;
          stWdata <= hostWdata;
        end
      end
    end else begin : g_direct
      assign stSel   = hostSel;
      assign stWe    = hostWe;
      assign stAddr  = hostAddr;
      assign stWdata = hostWdata;
    end
  endgenerate

  always_comb begin
    strb.field = stAddr[OFFS_W +: 4];
    strb.hit   = stSel && (stAddr[ADDR_W-1 -: BASE_W] == BASE_W'(BASE));
    strb.ctrl  = (strb.field == CODE_NONE);
    strb.we    = stWe;
  end

  assign offs  = stAddr[OFFS_W-1:0];
  assign wdata = stWdata;

  always_ff @(posedge clk) begin
    if (!rstN) hostAck <= 1'b0;
    else       hostAck <= strb.hit;
  end
endmodule

// File: rtl/slotbus_dp.sv
module slotbus_dp
  import slotbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OFFS_W = 4,
  parameter int unsigned SLOTS  = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [OFFS_W-1:0]       offs,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [SLOTS*DATA_W-1:0] slotRdata,
  output logic [SLOTS-1:0]        slotSel,
  output logic                    slotWe,
  output logic [DATA_W-1:0]       hostRdata,
  output logic                    codeClash
);
  logic [3:0]        codes [SLOTS];
  logic [DATA_W-1:0] slotOr;
  logic [3:0]        codeRd;

  generate
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rstN)
          codes[i] <= CODE_NONE;
        else if (strb.hit && strb.ctrl && strb.we && offs == OFFS_W'(i))
          codes[i] <= wdata[3:0];
      end
      assign slotSel[i] = strb.hit && !strb.ctrl && (codes[i] == strb.field);
    end
  endgenerate

  assign slotWe = strb.hit && !strb.ctrl && strb.we && (slotSel != '0);

  always_comb begin
    slotOr = '0;
    codeRd = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slotSel[i]) slotOr |= slotRdata[i*DATA_W +: DATA_W];
      if (offs == OFFS_W'(i)) codeRd = codes[i];
    end
  end

  always_comb begin
    codeClash = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      for (int j = i + 1; j < SLOTS; j++)
        if (codes[i] == codes[j] && codes[i] != CODE_NONE) codeClash = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    hostRdata <= '0;
    else if (!strb.hit || strb.we) hostRdata <= '0;
    else if (strb.ctrl)           hostRdata <= DATA_W'(codeRd);
    else                          hostRdata <= slotOr;
  end
endmodule

// File: rtl/slot_bus_decoder.sv
module slot_bus_decoder
  import slotbus_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned OFFS_W     = 4,
  parameter int unsigned SLOTS      = 3,
  parameter int unsigned BASE       = 'hA5,
  parameter bit          PIPE       = 1'b0,
  parameter bit          GLB_RST_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostSel,
  input  logic                    hostWe,
  input  logic [ADDR_W-1:0]       hostAddr,
  input  logic [DATA_W-1:0]       hostWdata,
  output logic [DATA_W-1:0]       hostRdata,
  output logic                    hostAck,
  output logic [SLOTS-1:0]        slotSel,
  output logic                    slotWe,
  output logic [OFFS_W-1:0]       slotOffs,
  output logic [DATA_W-1:0]       slotWdata,
  input  logic [SLOTS*DATA_W-1:0] slotRdata,
  input  logic [SLOTS-1:0]        slotLoading,
  input  logic                    globalRst,
  output logic [SLOTS-1:0]        slotRst,
  output logic                    codeClash
);
  strobe_t strb;

  slotbus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W),
                 .BASE(BASE), .PIPE(PIPE)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .strb(strb),
    .offs(slotOffs), .wdata(slotWdata), .hostAck(hostAck));

  slotbus_dp #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .SLOTS(SLOTS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .offs(slotOffs), .wdata(slotWdata),
    .slotRdata(slotRdata), .slotSel(slotSel), .slotWe(slotWe),
    .hostRdata(hostRdata), .codeClash(codeClash));

  generate
    if (GLB_RST_EN) begin : g_glb
      assign slotRst = slotLoading | {SLOTS{globalRst}};
    end else begin : g_local
      assign slotRst = slotLoading;
    end
  endgenerate
endmodule

// File: rtl/slotbus_chk.sv
module slotbus_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFFS_W = 4,
  parameter int unsigned SLOTS  = 3,
  parameter int unsigned BASE   = 'hA5,
  parameter bit          PIPE   = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostSel,
  input logic [ADDR_W-1:0] hostAddr,
  input logic              hostAck,
  input logic [SLOTS-1:0]  slotSel,
  input logic              slotWe,
  input logic [SLOTS-1:0]  slotLoading,
  input logic [SLOTS-1:0]  slotRst,
  input logic              codeClash
);
  localparam int unsigned BASE_W = ADDR_W - OFFS_W - 4;
  localparam int unsigned LAT    = PIPE ? 2 : 1;

  // R8: a loading slot is always held in reset
  p_load_rst_r8: assert property (@(posedge clk) disable iff (!rstN)
    (slotLoading & ~slotRst) == '0);

  // R9: acknowledge comes exactly LAT cycles after a request
  p_ack_lat_r9: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> $past(hostSel, LAT));

  // R2: acknowledge only for requests inside the base window
  p_base_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostAck |-> $past(hostAddr[ADDR_W-1 -: BASE_W] == BASE_W'(BASE), LAT));

  // R10: write strobe needs a selected slot
  p_we_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    slotWe |-> (slotSel != '0));

  // R6: multiple selects only under a reported clash
  p_clash_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(slotSel) > 1) |-> codeClash);
endmodule

bind slot_bus_decoder slotbus_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W),
  .SLOTS(SLOTS), .BASE(BASE), .PIPE(PIPE)) u_chk (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostAddr(hostAddr),
  .hostAck(hostAck), .slotSel(slotSel), .slotWe(slotWe),
  .slotLoading(slotLoading), .slotRst(slotRst), .codeClash(codeClash));

// File: tb/test_slot_bus_decoder.sv
`timescale 1ns/1ps
module test_slot_bus_decoder;
  localparam int SLOTS = 3;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 1'b0, hostWe = 1'b0, globalRst = 1'b0;
  logic [15:0] hostAddr = '0, hostWdata = '0;
  logic [SLOTS-1:0] slotLoading = '0;

  logic [DW-1:0] hostRdata, pRdata, slotWdata, pWdata;
  logic hostAck, pAck, slotWe, pWe, codeClash, pClash;
  logic [SLOTS-1:0] slotSel, pSel, slotRst, pRst;
  logic [3:0] slotOffs, pOffs;
  logic [SLOTS*DW-1:0] slotRdata, pSlotRdata;

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // slot i answers ((i+1)<<12) | offset; unselected words must be masked
  always_comb
    for (int i = 0; i < SLOTS; i++) begin
      slotRdata[i*DW +: DW]  = DW'(((i + 1) << 12) | slotOffs);
      pSlotRdata[i*DW +: DW] = DW'((i + 1) << 8);
    end

  slot_bus_decoder i_slot_bus_decoder (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .hostAck(hostAck), .slotSel(slotSel), .slotWe(slotWe),
    .slotOffs(slotOffs), .slotWdata(slotWdata), .slotRdata(slotRdata),
    .slotLoading(slotLoading), .globalRst(globalRst), .slotRst(slotRst),
    .codeClash(codeClash));

  slot_bus_decoder #(.PIPE(1'b1)) i_pipe (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(pRdata),
    .hostAck(pAck), .slotSel(pSel), .slotWe(pWe),
    .slotOffs(pOffs), .slotWdata(pWdata), .slotRdata(pSlotRdata),
    .slotLoading(slotLoading), .globalRst(globalRst), .slotRst(pRst),
    .codeClash(pClash));

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [15:0] wd;
    logic [2:0]  sel;
    logic        ack;
    logic [15:0] dat;
  } vec_t;

  // address = {base 8'hA5, slot field, offset}; field F is the control page
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'hA500, 16'h0000, 3'b000, 1'b1, 16'h0000},  // R4 R7 no codes yet
    '{1'b1, 16'hA5F0, 16'h0002, 3'b000, 1'b1, 16'h0000},  // R5 slot0 code 2
    '{1'b1, 16'hA5F1, 16'h0005, 3'b000, 1'b1, 16'h0000},  // R5 slot1 code 5
    '{1'b0, 16'hA523, 16'h0000, 3'b001, 1'b1, 16'h1003},  // R3 R1 slot0
    '{1'b0, 16'hA557, 16'h0000, 3'b010, 1'b1, 16'h2007},  // R3 R1 slot1
    '{1'b0, 16'hA570, 16'h0000, 3'b000, 1'b1, 16'h0000},  // R7 empty code
    '{1'b0, 16'hA5F0, 16'h0000, 3'b000, 1'b1, 16'h0002},  // R5 readback
    '{1'b0, 16'hA5F2, 16'h0000, 3'b000, 1'b1, 16'h000F},  // R4 default code
    '{1'b0, 16'h5A23, 16'h0000, 3'b000, 1'b0, 16'h0000},  // R2 other base
    '{1'b1, 16'hA55C, 16'hBEEF, 3'b010, 1'b1, 16'h0000},  // R10 R1 data write
    '{1'b1, 16'hA5F2, 16'h0002, 3'b000, 1'b1, 16'h0000},  // R6 duplicate code
    '{1'b0, 16'hA521, 16'h0000, 3'b101, 1'b1, 16'h3001},  // R6 OR of two slots
    '{1'b0, 16'hA5F9, 16'h0000, 3'b000, 1'b1, 16'h0000}   // R5 index out of range
  };

  task automatic access(input vec_t v, input int k);
    @(negedge clk);
    hostSel = 1'b1; hostWe = v.we; hostAddr = v.addr; hostWdata = v.wd;
    #1;
    chk(slotSel == v.sel, $sformatf("R3 R6 vec%0d slotSel", k), slotSel, v.sel);
    chk(slotWe == (v.we && v.sel != 0), $sformatf("R10 vec%0d slotWe", k), slotWe, v.we && v.sel != 0);
    chk(slotOffs == v.addr[3:0] && slotWdata == v.wd, $sformatf("R1 vec%0d offs/wdata", k), slotOffs, v.addr[3:0]);
    @(negedge clk);
    hostSel = 1'b0; hostWe = 1'b0;
    chk(hostAck == v.ack, $sformatf("R2 R9 vec%0d ack", k), hostAck, v.ack);
    chk(hostRdata == v.dat, $sformatf("R7 vec%0d rdata", k), hostRdata, v.dat);
  endtask

  initial begin
    #200000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(hostAck == 0 && slotSel == 0, "R4 reset ack/sel", {hostAck, slotSel}, 0);
    chk(codeClash == 0 && slotRst == 0, "R4 reset clash/rst", {codeClash, slotRst}, 0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) access(VECS[k], k);

    chk(codeClash == 1, "R6 clash flag", codeClash, 1);

    // R9: pipelined copy answers one cycle later
    @(negedge clk);
    hostSel = 1'b1; hostAddr = 16'hA550;
    @(negedge clk);
    hostSel = 1'b0;
    chk(pAck == 0, "R9 pipe ack not at +1", pAck, 0);
    chk(hostAck == 1, "R9 direct ack at +1", hostAck, 1);
    @(negedge clk);
    chk(pAck == 1 && pRdata == 16'h0200, "R9 pipe ack/data at +2", pRdata, 16'h0200);

    // R6: remove duplicate
    access('{1'b1, 16'hA5F2, 16'h000F, 3'b000, 1'b1, 16'h0000}, 90);
    chk(codeClash == 0, "R6 clash cleared", codeClash, 0);

    // R8: loading and global reset
    @(negedge clk);
    slotLoading = 3'b010; #1;
    chk(slotRst == 3'b010, "R8 loading reset", slotRst, 3'b010);
    globalRst = 1'b1; #1;
    chk(slotRst == 3'b111, "R8 global merge", slotRst, 3'b111);
    @(negedge clk);
    slotLoading = '0; globalRst = 1'b0; #1;
    chk(slotRst == 3'b000, "R8 released", slotRst, 0);

    // R4: reset returns codes to 4'hF
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    access('{1'b0, 16'hA5F0, 16'h0000, 3'b000, 1'b1, 16'h000F}, 91);
    access('{1'b0, 16'hA523, 16'h0000, 3'b000, 1'b1, 16'h0000}, 92);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule